// File: doc/BRIEF.md
# Conversion Result Accumulator with Atomic Snapshot

This block sits behind an analog converter that delivers one 12-bit result at a time, each tagged with a channel code. Codes 0 to 3 are the four measured analog channels. Code 4 is the multiplexed input. While sampling is enabled, the block adds every result of channels 0 to 3 into a 64-bit running sum kept for that channel. It also counts the completed sample sequences in 32 bits and the elapsed clock cycles in 64 bits. It keeps the most recent raw result of all five sources.

Software cannot read a 64-bit sum in one access while the sum keeps moving. For that reason every read goes to a set of shadow registers. A one-cycle write strobe arms a snapshot bit. The bit stays high for exactly one cycle and clears itself. At the edge where it is high, all live values are copied into the shadows together. Accumulation carries on without a pause.

Top module: `adc_accum_snap`

## Requirements
- R1: After reset every readable register returns 0 and `snap_pend` is 0.
- R2: The first clock edge with `samp_en` high after a low (or after reset) clears the four sums, the sequence counter and the cycle counter. A result present in that cycle is not added to any sum.
- R3: On each later edge with `samp_en` high, a valid result with channel code c in 0..3 adds its 12-bit value to the 64-bit sum of channel c.
- R4: On each later edge with `samp_en` high, a valid result with channel code 3 increments the 32-bit sequence counter.
- R5: On each later edge with `samp_en` high, the 64-bit cycle counter increments by one. The clearing edge leaves it at 0.
- R6: While `samp_en` is low, sums, counters and latest results all hold, and incoming results have no effect.
- R7: A `snap_wr` pulse sets `snap_pend` at the next edge, and `snap_pend` stays high for only one cycle unless `snap_wr` is still high. At the edge where `snap_pend` is high, every shadow takes the live value. At all other edges the shadows hold.
- R8: While `samp_en` is high, a valid result with code 0..4 becomes that source's latest result, including on the clearing edge. Codes 5 to 7 are ignored.
- R9: `rd_data` shows the shadow selected by `rd_addr` combinationally, with values zero-extended to 32 bits. The address map is:
  - 0: cycle counter, low word
  - 1: cycle counter, high word
  - 2: sequence counter
  - 3: latest result of the multiplexed input
  - 4 to 7: latest result of channels 0 to 3
  - 8+2c: sum of channel c, low word
  - 9+2c: sum of channel c, high word

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_en | input | 1 | Sampling enable |
| conv_vld | input | 1 | Converter result valid |
| conv_ch | input | 3 | Channel code of the result (0..3 channels, 4 multiplexed input) |
| conv_data | input | 12 | Conversion result |
| snap_wr | input | 1 | Snapshot request strobe |
| snap_pend | output | 1 | Self-clearing snapshot bit |
| rd_addr | input | 4 | Read-out register select |
| rd_data | output | 32 | Selected shadow register |

## Verification
Any input sampled at edge k updates the live state at edge k. The live state becomes visible at the port only after a snapshot. A `snap_wr` at edge k raises `snap_pend` after k, and the shadows copy the live state at edge k+1. `rd_data` then follows `rd_addr` within the same cycle. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. On every falling edge it steps `rd_addr` through the map, waits a moment and compares `rd_data` and `snap_pend` with the model. Each result is therefore checked in the cycle it is due, never earlier.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;
   // read-out map anchors; sums follow the per-channel latest words
   localparam int unsigned MAP_CYC_LO    = 0;
   localparam int unsigned MAP_CYC_HI    = 1;
   localparam int unsigned MAP_SEQ       = 2;
   localparam int unsigned MAP_MUX       = 3;
   localparam int unsigned MAP_LAST_BASE = 4;
endpackage

// File: rtl/adc_chan_acc.sv
module adc_chan_acc #(
   parameter int unsigned RW = 12,
   parameter int unsigned SW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          acc,
   input  logic          upd_last,
   input  logic [RW-1:0] data,
   output logic [SW-1:0] sum_o,
   output logic [RW-1:0] last_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o  <= '0;
         last_o <= '0;
      end else begin
         if (clr)
            sum_o <= '0;
         else if (acc)
            sum_o <= sum_o + SW'(data);
         if (upd_last)
            last_o <= data;
      end
   end
endmodule

// File: rtl/adc_run_cnt.sv
module adc_run_cnt #(
   parameter int unsigned QW = 32,
   parameter int unsigned CW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic          seq_hit,
   output logic [QW-1:0] seq_o,
   output logic [CW-1:0] cyc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_o <= '0;
         cyc_o <= '0;
      end else if (clr) begin
         seq_o <= '0;
         cyc_o <= '0;
      end else if (run) begin
         cyc_o <= cyc_o + CW'(1);
         if (seq_hit)
            seq_o <= seq_o + QW'(1);
      end
   end
endmodule

// File: rtl/adc_accum_snap.sv
module adc_accum_snap #(
   parameter int unsigned NCH = 4,
   parameter int unsigned RW  = 12,
   parameter int unsigned SW  = 64,
   parameter int unsigned QW  = 32,
   parameter int unsigned CW  = 64,
   parameter int unsigned DW  = 32,
   localparam int unsigned CHW = $clog2(NCH + 1),
   localparam int unsigned AW  = $clog2(4 + 3 * NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           samp_en,
   input  logic           conv_vld,
   input  logic [CHW-1:0] conv_ch,
   input  logic [RW-1:0]  conv_data,
   input  logic           snap_wr,
   output logic           snap_pend,
   input  logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_data
);
   import adc_acc_pkg::*;

   localparam int unsigned SUM_BASE = MAP_LAST_BASE + NCH;

   if (NCH < 1)             $error("NCH must be at least 1");
   if (SW <= RW)            $error("SW must exceed RW");
   if (SW > 2 * DW)         $error("SW must fit two read words");
   if (CW > 2 * DW)         $error("CW must fit two read words");
   if (QW > DW || RW > DW)  $error("QW and RW must fit one read word");

   logic          en_q;
   logic          clr, run;
   logic [SW-1:0] live_sum [NCH];
   logic [RW-1:0] live_last [NCH+1];
   logic [QW-1:0] live_seq;
   logic [CW-1:0] live_cyc;
   logic [SW-1:0] sh_sum [NCH];
   logic [RW-1:0] sh_last [NCH+1];
   logic [QW-1:0] sh_seq;
   logic [CW-1:0] sh_cyc;

   assign clr = samp_en & ~en_q;
   assign run = samp_en &  en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         snap_pend <= 1'b0;
      end else begin
         en_q      <= samp_en;
         snap_pend <= snap_wr;
      end
   end

   for (genvar g = 0; g <= NCH; g++) begin : g_src
      logic hit;
      assign hit = samp_en & conv_vld & (conv_ch == CHW'(g));
      if (g < NCH) begin : g_acc
         adc_chan_acc #(.RW(RW), .SW(SW)) i_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .acc      (run & hit),
            .upd_last (hit),
            .data     (conv_data),
            .sum_o    (live_sum[g]),
            .last_o   (live_last[g])
         );
      end else begin : g_mux
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               live_last[g] <= '0;
            else if (hit)
               live_last[g] <= conv_data;
         end
      end
   end

   adc_run_cnt #(.QW(QW), .CW(CW)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .run     (run),
      .seq_hit (conv_vld & (conv_ch == CHW'(NCH - 1))),
      .seq_o   (live_seq),
      .cyc_o   (live_cyc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_seq <= '0;
         sh_cyc <= '0;
         for (int c = 0; c < NCH; c++) sh_sum[c] <= '0;
         for (int c = 0; c <= NCH; c++) sh_last[c] <= '0;
      end else if (snap_pend) begin
         sh_seq <= live_seq;
         sh_cyc <= live_cyc;
         for (int c = 0; c < NCH; c++) sh_sum[c] <= live_sum[c];
         for (int c = 0; c <= NCH; c++) sh_last[c] <= live_last[c];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(MAP_CYC_LO)) rd_data = DW'(sh_cyc);
      if (rd_addr == AW'(MAP_CYC_HI)) rd_data = DW'(sh_cyc >> DW);
      if (rd_addr == AW'(MAP_SEQ))    rd_data = DW'(sh_seq);
      if (rd_addr == AW'(MAP_MUX))    rd_data = DW'(sh_last[NCH]);
      for (int c = 0; c < NCH; c++) begin
         if (rd_addr == AW'(MAP_LAST_BASE + c))  rd_data = DW'(sh_last[c]);
         if (rd_addr == AW'(SUM_BASE + 2*c))     rd_data = DW'(sh_sum[c]);
         if (rd_addr == AW'(SUM_BASE + 2*c + 1)) rd_data = DW'(sh_sum[c] >> DW);
      end
   end
endmodule

// File: rtl/adc_accum_snap_chk.sv
module adc_accum_snap_chk #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CHW = 3,
   parameter int unsigned QW  = 32,
   parameter int unsigned CW  = 64
) (
   input logic           clk,
   input logic           rst_n,
   input logic           samp_en,
   input logic           en_q,
   input logic           conv_vld,
   input logic [CHW-1:0] conv_ch,
   input logic           snap_wr,
   input logic           snap_pend,
   input logic [QW-1:0]  seq_cnt,
   input logic [CW-1:0]  cyc_cnt,
   input logic [CW-1:0]  sh_cyc
);
   AST_CLEAR_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && !en_q) |=> (cyc_cnt == '0 && seq_cnt == '0));   // R2
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && en_q && conv_vld && conv_ch == CHW'(NCH - 1))
      |=> seq_cnt == $past(seq_cnt) + QW'(1));                     // R4
   AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && en_q) |=> cyc_cnt == $past(cyc_cnt) + CW'(1));   // R5
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> ($stable(cyc_cnt) && $stable(seq_cnt)));        // R6
   AST_PEND_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_wr |=> !snap_pend);                                     // R7
   AST_SHADOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      snap_pend |=> sh_cyc == $past(cyc_cnt));                      // R7
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_pend |=> $stable(sh_cyc));                              // R7
endmodule

bind adc_accum_snap adc_accum_snap_chk #(
   .NCH(NCH), .CHW(CHW), .QW(QW), .CW(CW)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .samp_en   (samp_en),
   .en_q      (en_q),
   .conv_vld  (conv_vld),
   .conv_ch   (conv_ch),
   .snap_wr   (snap_wr),
   .snap_pend (snap_pend),
   .seq_cnt   (live_seq),
   .cyc_cnt   (live_cyc),
   .sh_cyc    (sh_cyc)
);

// File: tb/test_adc_accum_snap.sv
`timescale 1ns/1ps
module test_adc_accum_snap;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        samp_en = 1'b0;
   logic        conv_vld = 1'b0;
   logic [2:0]  conv_ch = '0;
   logic [11:0] conv_data = '0;
   logic        snap_wr = 1'b0;
   logic        snap_pend;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string phase = "R1";

   always #2 clk = ~clk;   // 250 MHz

   adc_accum_snap i_adc_accum_snap (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .conv_vld(conv_vld),
      .conv_ch(conv_ch), .conv_data(conv_data), .snap_wr(snap_wr),
      .snap_pend(snap_pend), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // behavioural reference model
   longint unsigned m_sum [4], s_sum [4];
   int unsigned     m_last [5], s_last [5];
   int unsigned     m_seq, s_seq;
   longint unsigned m_cyc, s_cyc;
   bit              m_enq, m_pend;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_enq = 0; m_pend = 0; m_seq = 0; s_seq = 0; m_cyc = 0; s_cyc = 0;
         foreach (m_sum[i]) begin m_sum[i] = 0; s_sum[i] = 0; end
         foreach (m_last[i]) begin m_last[i] = 0; s_last[i] = 0; end
      end else begin
         if (m_pend) begin
            s_sum = m_sum; s_last = m_last; s_seq = m_seq; s_cyc = m_cyc;
         end
         m_pend = snap_wr;
         if (samp_en) begin
            if (conv_vld && conv_ch <= 4) m_last[conv_ch] = conv_data;
            if (!m_enq) begin
               foreach (m_sum[i]) m_sum[i] = 0;
               m_seq = 0; m_cyc = 0;
            end else begin
               m_cyc++;
               if (conv_vld && conv_ch < 4) m_sum[conv_ch] += conv_data;
               if (conv_vld && conv_ch == 3) m_seq++;
            end
         end
         m_enq = samp_en;
      end
   end

   function automatic logic [31:0] exp_rd(int a);
      if (a == 0) return s_cyc[31:0];
      if (a == 1) return s_cyc[63:32];
      if (a == 2) return s_seq;
      if (a == 3) return s_last[4];
      if (a < 8)  return s_last[a-4];
      if (a[0] == 1'b0) return s_sum[(a-8)/2][31:0];
      return s_sum[(a-8)/2][63:32];
   endfunction

   function automatic string addr_req(int a);
      if (a < 2) return "R5";
      if (a == 2) return "R4";
      if (a < 8) return "R8";
      return "R3";
   endfunction

   // compare on every clock, away from the rising edge
   always @(negedge clk) begin
      if (!done) begin
         automatic logic [31:0] e;
         rd_addr <= rd_addr + 4'd1;
         #1;
         e = exp_rd(int'(rd_addr));
         checks++;
         if (rd_data !== e) begin
            errors++;
            $display("FAIL %s R9 phase %s addr %0d: actual %h expected %h",
                     addr_req(int'(rd_addr)), phase, rd_addr, rd_data, e);
         end
         checks++;
         if (snap_pend !== m_pend) begin
            errors++;
            $display("FAIL R7 phase %s snap_pend: actual %b expected %b",
                     phase, snap_pend, m_pend);
         end
      end
   end

   task automatic cyc(bit v, int ch, int d, bit s);
      @(negedge clk);
      conv_vld = v; conv_ch = 3'(ch); conv_data = 12'(d); snap_wr = s;
   endtask

   initial begin
      repeat (40) cyc(0, 0, 0, 0);    // reset phase, R1
      @(negedge clk); rst_n = 1'b1;
      repeat (20) cyc(0, 0, 0, 0);

      phase = "R2";                    // first enable clears, result ignored
      @(negedge clk); samp_en = 1'b1;
      conv_vld = 1; conv_ch = 3'd0; conv_data = 12'hABC;
      repeat (40) cyc(0, 0, 0, (1));
      repeat (20) cyc(0, 0, 0, 0);

      phase = "R3";                    // dense stream on all sources
      for (int i = 0; i < 300; i++)
         cyc(1, i % 5, (i * 397 + 11) & 12'hFFF, (i % 7) == 0);
      for (int i = 0; i < 300; i++)   // sparse, reversed, full-scale values
         cyc(i % 3 != 0, 4 - (i % 5), (i % 2) ? 12'hFFF : i, (i % 11) == 0);
      repeat (20) cyc(0, 0, 0, 1);

      phase = "R8";                    // unused channel codes
      for (int i = 0; i < 60; i++) cyc(1, 5 + (i % 3), i * 33, (i % 5) == 0);
      repeat (20) cyc(0, 0, 0, 1);

      phase = "R6";                    // disabled: everything holds
      @(negedge clk); samp_en = 1'b0;
      for (int i = 0; i < 120; i++) cyc(1, i % 5, 12'hFFF - i, (i % 9) == 0);
      repeat (20) cyc(0, 0, 0, 1);

      phase = "R2";                    // re-enable clears again
      @(negedge clk); samp_en = 1'b1; conv_vld = 0; snap_wr = 0;
      for (int i = 0; i < 200; i++) cyc(1, (i * 3) % 5, i * 7, 0);

      phase = "R7";                    // isolated and back-to-back snapshots
      for (int i = 0; i < 200; i++) cyc(1, i % 4, i + 100, (i % 13) < 3);
      repeat (20) cyc(0, 0, 0, 1);
      repeat (20) cyc(0, 0, 0, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule